// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Scheduler

This block is an out-of-order issue and execute slice for register-to-register operations. Decoded instructions enter a small in-order queue. The instruction at the head of the queue is placed into a free reservation station of the unit type it needs. Its destination register is then renamed to that station's number. Each source operand is either read from the register file or replaced by the tag of the station that will produce it.

A station fires once both of its operands are present. Stations are not served in allocation order. An adder station can go ahead of an older one that is still waiting, and a multiplier station can likewise go ahead of an older multiplier station. Finished results share one broadcast bus. Waiting stations pick up a result by matching its tag, and so does the register-status table. The final register contents always equal those of strictly sequential execution.

A testbench or a neighbouring block observes the scheduler through two outputs: a register read port, and a registered copy of every bus broadcast.

Top module: `tagrn_core`

## Requirements
- R1: After reset, register k reads back the value k, `bcast_valid` is 0 and `in_ready` is 1.
- R2: Instructions leave the queue strictly in arrival order. If no station of the head's type is free, the head waits. Nothing behind the head issues during that wait, even when its own type has a free station.
- R3: An instruction that depends on an earlier result waits in its station until that result is broadcast, then computes with it.
- R4: A younger station whose operands are ready executes before an older station that is still waiting, so its broadcast is seen first.
- R5: Renaming the destination at issue removes write-after-read and write-after-write hazards. A later writer never disturbs an earlier reader's source value.
- R6: At most one result is broadcast per cycle. When several results are ready in the same cycle, the station allocated earliest wins. The `bcast_*` outputs show each broadcast's tag and value one cycle later.
- R7: A register takes a broadcast value only if its status still names the broadcast tag. When it does, it is marked as having no pending producer.
- R8: For any instruction stream, the final register contents equal those of sequential execution, and every instruction is broadcast exactly once.
- R9: Opcode 00 adds, 01 subtracts (first source minus second), and 1x multiplies, keeping the low DW bits. Adder stations carry tags 0..NALU-1 and multiplier stations carry the tags after them. The lowest-numbered free station of the needed type is allocated.
- R10: `in_ready` is 0 while the queue holds QDEPTH entries.
- R11: At issue, a source with no pending producer takes the register value. A source whose producer is broadcasting in that same cycle takes the broadcast value.
- R12: A station becomes free in the cycle after its broadcast and may be allocated again from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Queue can accept an instruction |
| in_op | input | 2 | Opcode (00 add, 01 sub, 1x multiply) |
| in_dst | input | 3 | Destination register |
| in_src_a | input | 3 | First source register |
| in_src_b | input | 3 | Second source register |
| peek_addr | input | 3 | Register read address |
| peek_data | output | 16 | Register value, one cycle after the address |
| bcast_valid | output | 1 | A broadcast took place in the previous cycle |
| bcast_tag | output | 3 | Producing station of that broadcast |
| bcast_data | output | 16 | Value of that broadcast |

## Verification
The instruction streams are chosen so that the order of the broadcast tags tells each scheduling rule apart from its obvious wrong version.

- A run of independent additions checks station reuse and lowest-free allocation.
- A slow multiply followed by one dependent and one independent addition separates out-of-order dispatch from in-order dispatch.
- Three multiplies followed by an addition separate a stalled head from an issue that skips past the head. In the same stream, a multiply and the addition become ready together, which exposes the age arbitration.
- Streams that rewrite a register still awaited by an earlier instruction, long dependent chains and a pseudo-random stream are compared against a sequential model of the register file.

// File: rtl/tagrn_pkg.sv
package tagrn_pkg;
  // Opcode values; bit 1 selects the multiplier unit.
  localparam logic [1:0] OPC_ADD = 2'b00;
  localparam logic [1:0] OPC_SUB = 2'b01;
  localparam logic [1:0] OPC_MUL = 2'b10;

  function automatic logic op_needs_mul(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/tagrn_fifo.sv
module tagrn_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
endmodule

// File: rtl/tagrn_regfile.sv
module tagrn_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 3,
  localparam int RA  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RA-1:0] ra1,
  input  logic [RA-1:0] ra2,
  output logic [DW-1:0] rv1,
  output logic [DW-1:0] rv2,
  output logic          rp1,
  output logic          rp2,
  output logic [TW-1:0] rt1,
  output logic [TW-1:0] rt2,
  input  logic [RA-1:0] peek_addr,
  output logic [DW-1:0] peek_data,
  input  logic          bus_v,
  input  logic [TW-1:0] bus_t,
  input  logic [DW-1:0] bus_d,
  input  logic          iss_en,
  input  logic [RA-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag
);
  logic [DW-1:0] rf   [NREG];
  logic [TW-1:0] ptag [NREG];
  logic [NREG-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) begin
        rf[r]   <= DW'(r);
        ptag[r] <= '0;
      end
      pend      <= '0;
      peek_data <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (bus_v && pend[r] && ptag[r] == bus_t) begin
          rf[r]   <= bus_d;
          pend[r] <= 1'b0;
        end
      end
      // Renaming at issue overrides a clear in the same cycle.
      if (iss_en) begin
        pend[iss_dst] <= 1'b1;
        ptag[iss_dst] <= iss_tag;
      end
      peek_data <= rf[peek_addr];
    end
  end

  assign rv1 = rf[ra1];
  assign rv2 = rf[ra2];
  assign rp1 = pend[ra1];
  assign rp2 = pend[ra2];
  assign rt1 = ptag[ra1];
  assign rt2 = ptag[ra2];
endmodule

// File: rtl/tagrn_stations.sv
module tagrn_stations #(
  parameter int NALU    = 3,
  parameter int NMUL    = 2,
  parameter int DW      = 16,
  parameter int MUL_LAT = 3,
  localparam int NST    = NALU + NMUL,
  localparam int TW     = $clog2(NST)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc_en,
  input  logic [TW-1:0]  alloc_idx,
  input  logic           alloc_sub,
  input  logic           a_rdy1,
  input  logic [DW-1:0]  a_val1,
  input  logic [TW-1:0]  a_tag1,
  input  logic           a_rdy2,
  input  logic [DW-1:0]  a_val2,
  input  logic [TW-1:0]  a_tag2,
  output logic [NST-1:0] free_mask,
  output logic           bus_v,
  output logic [TW-1:0]  bus_t,
  output logic [DW-1:0]  bus_d
);
  localparam int CW = $clog2(MUL_LAT + 1);
  localparam logic [CW-1:0]  MLOAD = CW'(MUL_LAT - 1);
  localparam logic [NST-1:0] ALU_M = {{NMUL{1'b0}}, {NALU{1'b1}}};

  logic [NST-1:0] busy, exec, done, sub, r1, r2;
  logic [DW-1:0]  v1 [NST];
  logic [DW-1:0]  v2 [NST];
  logic [TW-1:0]  t1 [NST];
  logic [TW-1:0]  t2 [NST];
  logic [DW-1:0]  res [NST];
  // age[i][j] = 1 when station j was allocated before station i.
  logic [NST-1:0] age [NST];

  logic          mbusy;
  logic [CW-1:0] mcnt;
  logic [TW-1:0] midx;
  logic [DW-1:0] ma, mb, prod;

  logic [NST-1:0] rdy_vec, alu_cand, mul_cand, alu_go, mul_go, bus_sel;
  logic [TW-1:0]  mul_idx;
  logic [DW-1:0]  alu_a, alu_b, alu_y;
  logic           alu_s;

  assign rdy_vec  = busy & ~exec & ~done & r1 & r2;
  assign alu_cand = rdy_vec & ALU_M;
  assign mul_cand = rdy_vec & ~ALU_M & {NST{~mbusy}};

  // Oldest-first selection per unit and for the shared bus.
  for (genvar i = 0; i < NST; i++) begin : g_sel
    assign alu_go[i]  = alu_cand[i] & ~|(age[i] & alu_cand);
    assign mul_go[i]  = mul_cand[i] & ~|(age[i] & mul_cand);
    assign bus_sel[i] = done[i]     & ~|(age[i] & done);
  end

  always_comb begin
    alu_a   = '0;
    alu_b   = '0;
    alu_s   = 1'b0;
    mul_idx = '0;
    bus_t   = '0;
    bus_d   = '0;
    for (int i = 0; i < NST; i++) begin
      if (alu_go[i]) begin
        alu_a = v1[i];
        alu_b = v2[i];
        alu_s = sub[i];
      end
      if (mul_go[i]) mul_idx = TW'(i);
      if (bus_sel[i]) begin
        bus_t = TW'(i);
        bus_d = res[i];
      end
    end
  end

  assign alu_y     = alu_s ? (alu_a - alu_b) : (alu_a + alu_b);
  assign prod      = ma * mb;
  assign bus_v     = |done;
  assign free_mask = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= '0;
      exec  <= '0;
      done  <= '0;
      sub   <= '0;
      r1    <= '0;
      r2    <= '0;
      mbusy <= 1'b0;
      mcnt  <= '0;
      midx  <= '0;
      ma    <= '0;
      mb    <= '0;
      for (int i = 0; i < NST; i++) begin
        v1[i]  <= '0;
        v2[i]  <= '0;
        t1[i]  <= '0;
        t2[i]  <= '0;
        res[i] <= '0;
        age[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NST; i++) begin
        if (busy[i] && !r1[i] && bus_v && t1[i] == bus_t) begin
          v1[i] <= bus_d;
          r1[i] <= 1'b1;
        end
        if (busy[i] && !r2[i] && bus_v && t2[i] == bus_t) begin
          v2[i] <= bus_d;
          r2[i] <= 1'b1;
        end
        if (alu_go[i]) begin
          res[i]  <= alu_y;
          done[i] <= 1'b1;
        end
        if (mul_go[i]) exec[i] <= 1'b1;
        if (bus_sel[i]) begin
          busy[i] <= 1'b0;
          done[i] <= 1'b0;
        end
        if (alloc_en && alloc_idx == TW'(i)) begin
          busy[i] <= 1'b1;
          exec[i] <= 1'b0;
          done[i] <= 1'b0;
          sub[i]  <= alloc_sub;
          r1[i]   <= a_rdy1;
          v1[i]   <= a_val1;
          t1[i]   <= a_tag1;
          r2[i]   <= a_rdy2;
          v2[i]   <= a_val2;
          t2[i]   <= a_tag2;
          age[i]  <= busy & ~bus_sel;
        end
        if (alloc_en) age[i][alloc_idx] <= 1'b0;
      end
      // Multiplier: one operation at a time, MUL_LAT cycles each.
      if (mbusy) begin
        if (mcnt == '0) begin
          res[midx]  <= prod;
          done[midx] <= 1'b1;
          exec[midx] <= 1'b0;
          mbusy      <= 1'b0;
        end else begin
          mcnt <= mcnt - 1'b1;
        end
      end else if (|mul_go) begin
        mbusy <= 1'b1;
        mcnt  <= MLOAD;
        midx  <= mul_idx;
        ma    <= v1[mul_idx];
        mb    <= v2[mul_idx];
      end
    end
  end
endmodule

// File: rtl/tagrn_core.sv
module tagrn_core #(
  parameter int NREG    = 8,
  parameter int DW      = 16,
  parameter int NALU    = 3,
  parameter int NMUL    = 2,
  parameter int MUL_LAT = 3,
  parameter int QDEPTH  = 4,
  localparam int RA     = $clog2(NREG),
  localparam int NST    = NALU + NMUL,
  localparam int TW     = $clog2(NST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [RA-1:0] in_dst,
  input  logic [RA-1:0] in_src_a,
  input  logic [RA-1:0] in_src_b,
  input  logic [RA-1:0] peek_addr,
  output logic [DW-1:0] peek_data,
  output logic          bcast_valid,
  output logic [TW-1:0] bcast_tag,
  output logic [DW-1:0] bcast_data
);
  import tagrn_pkg::*;

  localparam int IW = 2 + 3 * RA;
  localparam logic [NST-1:0] ALU_M = {{NMUL{1'b0}}, {NALU{1'b1}}};

  logic [IW-1:0]  head;
  logic           q_empty, q_full, push;
  logic [1:0]     h_op;
  logic [RA-1:0]  h_dst, h_sa, h_sb;
  logic           need_mul, iss_en;
  logic [NST-1:0] free_mask, avail;
  logic [TW-1:0]  iss_idx;

  logic [DW-1:0]  rv1, rv2, s_val1, s_val2;
  logic           rp1, rp2, s_rdy1, s_rdy2;
  logic [TW-1:0]  rt1, rt2;

  logic           bus_v;
  logic [TW-1:0]  bus_t;
  logic [DW-1:0]  bus_d;

  assign in_ready = ~q_full;
  assign push     = in_valid & ~q_full;

  tagrn_fifo #(.W(IW), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst(rst), .push(push),
    .din({in_op, in_dst, in_src_a, in_src_b}),
    .pop(iss_en), .dout(head), .empty(q_empty), .full(q_full)
  );

  assign {h_op, h_dst, h_sa, h_sb} = head;
  assign need_mul = op_needs_mul(h_op);
  assign avail    = free_mask & (need_mul ? ~ALU_M : ALU_M);
  assign iss_en   = ~q_empty & (|avail);

  // Lowest-numbered free station of the needed type.
  always_comb begin
    iss_idx = '0;
    for (int i = NST - 1; i >= 0; i--) begin
      if (avail[i]) iss_idx = TW'(i);
    end
  end

  tagrn_regfile #(.NREG(NREG), .DW(DW), .TW(TW)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(h_sa), .ra2(h_sb),
    .rv1(rv1), .rv2(rv2), .rp1(rp1), .rp2(rp2), .rt1(rt1), .rt2(rt2),
    .peek_addr(peek_addr), .peek_data(peek_data),
    .bus_v(bus_v), .bus_t(bus_t), .bus_d(bus_d),
    .iss_en(iss_en), .iss_dst(h_dst), .iss_tag(iss_idx)
  );

  // Operand resolution at issue, including same-cycle broadcast capture.
  always_comb begin
    s_rdy1 = ~rp1 | (bus_v & (bus_t == rt1));
    s_val1 = rp1 ? bus_d : rv1;
    s_rdy2 = ~rp2 | (bus_v & (bus_t == rt2));
    s_val2 = rp2 ? bus_d : rv2;
  end

  tagrn_stations #(.NALU(NALU), .NMUL(NMUL), .DW(DW), .MUL_LAT(MUL_LAT)) u_rs (
    .clk(clk), .rst(rst),
    .alloc_en(iss_en), .alloc_idx(iss_idx), .alloc_sub(h_op[0]),
    .a_rdy1(s_rdy1), .a_val1(s_val1), .a_tag1(rt1),
    .a_rdy2(s_rdy2), .a_val2(s_val2), .a_tag2(rt2),
    .free_mask(free_mask),
    .bus_v(bus_v), .bus_t(bus_t), .bus_d(bus_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bcast_valid <= 1'b0;
      bcast_tag   <= '0;
      bcast_data  <= '0;
    end else begin
      bcast_valid <= bus_v;
      bcast_tag   <= bus_t;
      bcast_data  <= bus_d;
    end
  end
endmodule

// File: rtl/tagrn_chk.sv
module tagrn_chk #(
  parameter int NALU = 3,
  parameter int NST  = 5,
  parameter int TW   = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           iss_en,
  input logic [TW-1:0]  iss_idx,
  input logic           need_mul,
  input logic [NST-1:0] free_mask,
  input logic           bus_v,
  input logic [TW-1:0]  bus_t,
  input logic           bcast_valid,
  input logic [TW-1:0]  bcast_tag
);
  assert_issue_free_R2: assert property (@(posedge clk) disable iff (rst)
    iss_en |-> free_mask[iss_idx]);

  assert_issue_type_R9: assert property (@(posedge clk) disable iff (rst)
    iss_en |-> ((iss_idx >= TW'(NALU)) == need_mul));

  assert_bus_owner_R6: assert property (@(posedge clk) disable iff (rst)
    bus_v |-> !free_mask[bus_t]);

  assert_bus_release_R12: assert property (@(posedge clk) disable iff (rst)
    bus_v |=> free_mask[$past(bus_t)]);

  assert_bus_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    bus_v |=> (bcast_valid && bcast_tag == $past(bus_t)));
endmodule

bind tagrn_core tagrn_chk #(.NALU(NALU), .NST(NST), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .iss_en(iss_en), .iss_idx(iss_idx),
  .need_mul(need_mul), .free_mask(free_mask),
  .bus_v(bus_v), .bus_t(bus_t),
  .bcast_valid(bcast_valid), .bcast_tag(bcast_tag)
);

// File: tb/sim_tagrn_core.sv
module sim_tagrn_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [2:0]  in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [2:0]  peek_addr = '0;
  logic [15:0] peek_data;
  logic        bcast_valid;
  logic [2:0]  bcast_tag;
  logic [15:0] bcast_data;

  int nchk = 0, nfail = 0, nlog = 0;
  bit done_flag = 0, saw_full = 0;
  int tlog [64];
  logic [15:0] dlog [64];
  logic [15:0] mdl [8];

  always #2 clk = ~clk;

  tagrn_core u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .peek_addr(peek_addr), .peek_data(peek_data),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_data(bcast_data)
  );

  always @(negedge clk) begin
    if (!rst && bcast_valid) begin
      if (nlog < 64) begin
        tlog[nlog] = int'(bcast_tag);
        dlog[nlog] = bcast_data;
      end
      nlog++;
    end
    if (!rst && in_valid && !in_ready) saw_full = 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  function automatic logic [15:0] ref_op(input logic [1:0] op,
                                         input logic [15:0] a, input logic [15:0] b);
    if (op[1])      return a * b;
    else if (op[0]) return a - b;
    else            return a + b;
  endfunction

  task automatic push(input logic [1:0] op, input int d, input int a, input int b);
    @(negedge clk);
    in_valid = 1; in_op = op;
    in_dst = 3'(d); in_src_a = 3'(a); in_src_b = 3'(b);
    mdl[d] = ref_op(op, mdl[a], mdl[b]);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input int a, output logic [15:0] v);
    @(negedge clk);
    peek_addr = 3'(a);
    @(negedge clk);
    v = peek_data;
  endtask

  task automatic check_regs(input string req);
    logic [15:0] v;
    for (int r = 0; r < 8; r++) begin
      peek(r, v);
      chk(req, int'(v), int'(mdl[r]));
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    logic [15:0] v;
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 bcast_valid", int'(bcast_valid), 0);
    for (int r = 0; r < 8; r++) begin
      peek(r, v);
      chk("R1 reg", int'(v), r);
    end
  endtask

  // R12, R9: six independent adds reuse the three adder stations
  task automatic t_reuse();
    nlog = 0;
    for (int k = 0; k < 6; k++) push(2'b00, 1 + (k % 3), 4, 5);
    settle(30);
    chk("R12 count", nlog, 6);
    for (int k = 0; k < 6; k++) chk("R12 tag order", tlog[k], k % 3);
    check_regs("R9 add");
  endtask

  // R4, R3: independent add overtakes a waiting dependent add
  task automatic t_bypass();
    logic [15:0] e;
    e = mdl[2] + mdl[2];
    nlog = 0;
    push(2'b10, 1, 2, 3);
    push(2'b00, 4, 1, 2);
    push(2'b00, 5, 2, 2);
    settle(30);
    chk("R4 first tag", tlog[0], 1);
    chk("R6 first data", int'(dlog[0]), int'(e));
    chk("R3 second tag", tlog[1], 3);
    chk("R4 third tag", tlog[2], 0);
    check_regs("R3 values");
  endtask

  // R2, R6: stalled multiply head blocks an add; tie goes to the oldest
  task automatic t_stall();
    nlog = 0;
    push(2'b10, 6, 2, 3);
    push(2'b10, 7, 3, 3);
    push(2'b11, 6, 6, 2);
    push(2'b00, 1, 2, 4);
    settle(40);
    chk("R2 count", nlog, 4);
    chk("R2 first tag", tlog[0], 3);
    chk("R6 oldest wins", tlog[1], 4);
    chk("R6 younger later", tlog[2], 0);
    chk("R12 reuse mul", tlog[3], 3);
    check_regs("R2 values");
  endtask

  // R5, R7: WAR and WAW on renamed registers
  task automatic t_rename();
    push(2'b10, 5, 2, 3);
    push(2'b00, 2, 3, 3);
    push(2'b00, 5, 1, 1);
    push(2'b01, 3, 5, 2);
    settle(30);
    check_regs("R5 R7 values");
  endtask

  // R9: subtract wrap and multiply truncation
  task automatic t_ops();
    push(2'b01, 6, 0, 7);
    push(2'b10, 4, 6, 6);
    push(2'b11, 3, 4, 6);
    push(2'b01, 2, 3, 3);
    settle(30);
    check_regs("R9 values");
  endtask

  // R10: queue fills behind busy multiplier stations
  task automatic t_full();
    saw_full = 0;
    for (int k = 0; k < 8; k++) push(2'b10, 1 + (k % 7), k % 8, (k + 3) % 8);
    settle(60);
    chk("R10 in_ready low when full", int'(saw_full), 1);
    check_regs("R10 values");
  endtask

  // R8, R11: pseudo-random stream against the sequential model
  task automatic t_stream();
    logic [15:0] lf = 16'hACE1;
    nlog = 0;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      push(lf[1:0], int'(lf[4:2]), int'(lf[7:5]), int'(lf[10:8]));
    end
    settle(120);
    chk("R8 one broadcast each", nlog, 60);
    check_regs("R8 R11 values");
  endtask

  initial begin
    for (int r = 0; r < 8; r++) mdl[r] = 16'(r);
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_reuse();
    t_bypass();
    t_stall();
    t_rename();
    t_ops();
    t_full();
    t_stream();
    finish_up();
  end
endmodule